// File: doc/BRIEF.md
# Hidden Refresh Controller for RAS-Only DRAM Arrays

This block keeps an array of simple 64 Kbit dynamic RAMs alive. These devices have no internal refresh. A free-running prescaler raises a row request about every 15.6 µs. The request is held until the processor enters the clock phase in which it never touches memory. At the first clock of that idle window the block runs a RAS-only cycle: the row counter value goes onto the address bus, RAS is pulled low for a set number of clocks, and then RAS stays high for a precharge time. CAS is never involved, so this block has no CAS output.

Two device generations are supported through one input. One generation needs 128 rows every 2 ms and the other needs 256 rows every 4 ms. Both give the same per-row interval, so only the point where the row counter wraps changes. While a sequence runs, the block drives a select that steers the DRAM address multiplexer to the refresh row. It also raises a busy flag so the access logic holds off. Because all refresh work sits inside the idle phase, the processor is never stalled.

Top module: `dram_hidden_refresh`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block leaves `ras_n` high, `ref_active` low, `addr_sel` low and `ref_row` zero.
- R2: A row request is raised once every `PRESCALE` clocks in both device configurations. With regular idle windows, successive RAS falls are exactly `PRESCALE` clocks apart.
- R3: A refresh sequence starts only at the first clock of an idle window, that is, at an edge where `phase1` is high and was low at the previous edge, and only when a request is pending. Otherwise `ras_n` never falls.
- R4: After a start, `ras_n` is low for exactly `RAS_CYC` clocks. It is then high for exactly `PRE_CYC` clocks while `ref_active` stays high.
- R5: `ref_row` does not change during a sequence. It advances by one after each served row.
- R6: With `cfg_long` = 0 the row counter wraps from 127 to 0, so bit 7 of `ref_row` is always 0. With `cfg_long` = 1 it wraps from 255 to 0.
- R7: `addr_sel` and `ref_active` are high for the whole sequence, including every clock in which `ras_n` is low.
- R8: Requests that arrive while `phase1` is held low stay pending. Any number of them are served as a single row at the next window start.
- R9: When the window is at least `RAS_CYC + PRE_CYC` clocks long, the sequence ends while `phase1` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase1 | input | 1 | High during the processor phase with no memory access |
| cfg_long | input | 1 | 0: 128-row device, 1: 256-row device |
| ref_row | output | ROW_BITS | Row address presented during refresh |
| ras_n | output | 1 | Row strobe, active low |
| ref_active | output | 1 | Refresh in progress; access logic must wait |
| addr_sel | output | 1 | Address mux select, 1 chooses the refresh row |

## Verification
The first window edge after a request becomes pending is the start edge. `ras_n` and `ref_active` change right after that edge. `ras_n` rises `RAS_CYC` edges later, `ref_active` drops `RAS_CYC + PRE_CYC` edges after the start, and `ref_row` takes its new value at that same edge. The bench samples every output 2 ns after each rising edge. It keeps a record of `phase1` as it stood at the current edge and at the previous one, so each transition is checked against the edge that caused it. Sweeps run over the full 128-row and 256-row cycles with a small prescaler, and a forced busy stretch covers collapsed requests.

// File: rtl/refresh_pkg.sv
// Shared types for the hidden refresh controller.
package refresh_pkg;
    // Sequencer phases of one RAS-only refresh
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_STROBE  = 2'd1,
        SQ_RECOVER = 2'd2
    } seq_state_t;
endpackage

// File: rtl/refresh_prescaler.sv
// Free-running divider that emits a one-clock request pulse every PRESCALE
// clocks. Assumes PRESCALE >= 2.
module refresh_prescaler #(
    parameter int PRESCALE = 1953
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PS_W = $clog2(PRESCALE);

    logic [PS_W-1:0] div_cnt;

    // Count 0..PRESCALE-1 and pulse tick on the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (div_cnt == PS_W'(PRESCALE - 1)) begin
            div_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick    <= 1'b0;
        end
    end
endmodule

// File: rtl/refresh_sequencer.sv
// Holds pending requests and runs the strobe/recover sequence. A sequence
// starts only on the first clock of an idle window. Assumes the window is
// at least RAS_CYC + PRE_CYC clocks long.
module refresh_sequencer
    import refresh_pkg::*;
#(
    parameter int RAS_CYC = 3,
    parameter int PRE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase1,
    input  logic tick,
    output logic ras_n,
    output logic busy,
    output logic row_done
);
    localparam int MAXC = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t      state;
    logic [CW-1:0]   cnt;
    logic            pending;
    logic            phase1_q;
    logic            start;

    // Start condition: idle, window opening edge, request waiting
    always_comb begin
        start    = (state == SQ_IDLE) && phase1 && !phase1_q && pending;
        row_done = (state == SQ_RECOVER) && (cnt == CW'(PRE_CYC - 1));
        ras_n    = (state != SQ_STROBE);
        busy     = (state != SQ_IDLE);
    end

    // Request latch and window-edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            phase1_q <= 1'b0;
        end else begin
            pending  <= (pending && !start) || tick;
            phase1_q <= phase1;
        end
    end

    // Sequence state and phase length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state <= SQ_STROBE;
                        cnt   <= '0;
                    end
                end
                SQ_STROBE: begin
                    if (cnt == CW'(RAS_CYC - 1)) begin
                        state <= SQ_RECOVER;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_RECOVER: begin
                    if (row_done) begin
                        state <= SQ_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SQ_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/refresh_row_counter.sv
// Refresh row counter. It wraps at 2**(ROW_BITS-1) rows or at 2**ROW_BITS
// rows, as selected by cfg_long. Advances on row_done only.
module refresh_row_counter #(
    parameter int ROW_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_long,
    input  logic                row_done,
    output logic [ROW_BITS-1:0] row
);
    logic [ROW_BITS-1:0] row_q;
    logic [ROW_BITS-1:0] mask;

    // Short devices use one row bit fewer
    always_comb begin
        mask = cfg_long ? {ROW_BITS{1'b1}} : {1'b0, {(ROW_BITS-1){1'b1}}};
        row  = row_q & mask;
    end

    // Step to the next row after each served refresh
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (row_done)
            row_q <= (row_q + 1'b1) & mask;
    end
endmodule

// File: rtl/dram_hidden_refresh.sv
// Top of the hidden refresh controller: prescaler, sequencer and row
// counter. Assumes phase1 is synchronous to clk and that each idle window
// lasts at least RAS_CYC + PRE_CYC clocks.
module dram_hidden_refresh #(
    parameter int PRESCALE = 1953,
    parameter int RAS_CYC  = 3,
    parameter int PRE_CYC  = 2,
    parameter int ROW_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                phase1,
    input  logic                cfg_long,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                ras_n,
    output logic                ref_active,
    output logic                addr_sel
);
    logic tick;
    logic row_done;
    logic busy;

    refresh_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    refresh_sequencer #(.RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase1  (phase1),
        .tick    (tick),
        .ras_n   (ras_n),
        .busy    (busy),
        .row_done(row_done)
    );

    refresh_row_counter #(.ROW_BITS(ROW_BITS)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_long(cfg_long),
        .row_done(row_done),
        .row     (ref_row)
    );

    // Busy drives both the hold-off flag and the address steering
    always_comb begin
        ref_active = busy;
        addr_sel   = busy;
    end
endmodule

// File: rtl/dram_hidden_refresh_chk.sv
// Property checker for dram_hidden_refresh, attached by bind.
module dram_hidden_refresh_chk #(
    parameter int ROW_BITS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                phase1,
    input logic                cfg_long,
    input logic [ROW_BITS-1:0] ref_row,
    input logic                ras_n,
    input logic                ref_active,
    input logic                addr_sel
);
    p_start_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(phase1));

    p_strobe_steered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (addr_sel && ref_active));

    p_row_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_active && $past(ref_active)) |-> $stable(ref_row));

    p_short_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_long |-> !ref_row[ROW_BITS-1]);

    p_end_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_active) |-> $past(phase1));
endmodule

bind dram_hidden_refresh dram_hidden_refresh_chk #(.ROW_BITS(ROW_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase1    (phase1),
    .cfg_long  (cfg_long),
    .ref_row   (ref_row),
    .ras_n     (ras_n),
    .ref_active(ref_active),
    .addr_sel  (addr_sel)
);

// File: tb/tb_dram_hidden_refresh.sv
// Bench: full row sweeps in both configurations plus a forced busy stretch.
module tb_dram_hidden_refresh;
    localparam int PRESCALE = 40;
    localparam int RAS_CYC  = 3;
    localparam int PRE_CYC  = 2;
    localparam int ROW_BITS = 8;
    localparam int WIN_PER  = 10;
    localparam int WIN_HIGH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase1 = 1'b0;
    logic cfg_long = 1'b0;
    logic busy_force = 1'b0;
    logic [ROW_BITS-1:0] ref_row;
    logic ras_n, ref_active, addr_sel;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    dram_hidden_refresh #(
        .PRESCALE(PRESCALE), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC), .ROW_BITS(ROW_BITS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .phase1(phase1), .cfg_long(cfg_long),
        .ref_row(ref_row), .ras_n(ras_n), .ref_active(ref_active), .addr_sel(addr_sel)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Idle-window generator: WIN_HIGH of every WIN_PER clocks, unless forced busy
    initial begin
        int pc = 0;
        forever begin
            @(negedge clk);
            if (busy_force) begin
                phase1 <= 1'b0;
                pc = 0;
            end else begin
                phase1 <= (pc < WIN_HIGH);
                pc = (pc + 1) % WIN_PER;
            end
        end
    end

    // Monitor state
    int  cyc = 0, fall_count = 0, last_fall = 0, low_len = 0, high_len = 0;
    int  exp_row = 0, max_row = 0;
    bit  have_prev = 0, interval_ok = 0;
    bit  prev_ras = 1, prev_act = 0, ph_prev = 0;

    // Sample 2 ns after each edge and check the sequence rules
    always @(posedge clk) begin
        #2;
        cyc++;
        if (!rst_n) begin
            exp_row = 0; max_row = 0; have_prev = 0;
            prev_ras = 1; prev_act = 0; ph_prev = phase1;
        end else begin
            if (!ras_n && !(addr_sel && ref_active))
                chk(0, "R7 steering during strobe", addr_sel, 1);
            if (!ras_n && prev_ras) begin
                fall_count++;
                chk(phase1 && !ph_prev, "R3 start at window edge", {ph_prev, phase1}, 2'b01);
                chk(int'(ref_row) == exp_row, "R5 row presented", ref_row, exp_row);
                if (int'(ref_row) > max_row) max_row = int'(ref_row);
                if (have_prev && interval_ok)
                    chk(cyc - last_fall == PRESCALE, "R2 refresh interval", cyc - last_fall, PRESCALE);
                have_prev = 1; last_fall = cyc; low_len = 1;
            end else if (!ras_n) begin
                low_len++;
            end
            if (ras_n && !prev_ras) begin
                chk(low_len == RAS_CYC, "R4 strobe length", low_len, RAS_CYC);
                chk(ref_active && addr_sel, "R7 active in recover", ref_active, 1);
                high_len = 1;
            end else if (ras_n && ref_active) begin
                high_len++;
            end
            if (prev_act && !ref_active) begin
                chk(high_len == PRE_CYC, "R4 precharge length", high_len, PRE_CYC);
                exp_row = (exp_row + 1) % (cfg_long ? 256 : 128);
                chk(int'(ref_row) == exp_row, "R5 row advance", ref_row, exp_row);
                chk(phase1, "R9 ends inside window", phase1, 1);
            end
            prev_ras = ras_n; prev_act = ref_active; ph_prev = phase1;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int base;
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ras_n == 1'b1, "R1 ras_n in reset", ras_n, 1);
        chk(ref_active == 1'b0, "R1 ref_active in reset", ref_active, 0);
        chk(addr_sel == 1'b0, "R1 addr_sel in reset", addr_sel, 0);
        chk(ref_row == '0, "R1 row in reset", ref_row, 0);
        rst_n = 1'b1;
        interval_ok = 1;

        // R6 short: sweep past the 128-row wrap
        wait (fall_count >= 135);
        @(negedge clk);
        chk(max_row == 127, "R6 short wrap max row", max_row, 127);

        // R8: forced busy stretch collapses several requests into one row
        wait (ref_active == 1'b0);
        @(negedge clk);
        interval_ok = 0;
        busy_force = 1'b1;
        base = fall_count;
        repeat (150) @(negedge clk);
        chk(fall_count == base, "R3 no refresh while busy", fall_count - base, 0);
        busy_force = 1'b0;
        repeat (8) @(negedge clk);
        chk(fall_count == base + 1, "R8 one refresh after busy", fall_count - base, 1);
        wait (fall_count >= base + 2);
        @(negedge clk);
        interval_ok = 1;
        wait (fall_count >= base + 6);
        @(negedge clk);

        // R6 long: reset, switch configuration, sweep past 256 rows
        rst_n = 1'b0;
        cfg_long = 1'b1;
        repeat (3) @(negedge clk);
        chk(ref_row == '0, "R1 row after second reset", ref_row, 0);
        base = fall_count;
        rst_n = 1'b1;
        wait (fall_count >= base + 262);
        @(negedge clk);
        chk(max_row == 255, "R6 long wrap max row", max_row, 255);

        summary();
        $finish;
    end
endmodule